// File: doc/BRIEF.md
# I2C SCL Phase Generator

This block produces the serial clock for an I2C master. Two programmable counts set the length of the low phase and the high phase. A prescaler selects whether one count tick is one input clock or two. The block pulls SCL low through an open-drain enable and releases it to let the line float high.

The low phase is timed from the moment the block starts pulling the line, so the programmed low count has to cover the fall time. The high phase is timed differently. Its counter starts only after a two-flop synchronizer reports the line high. Rise time is therefore left out of the high count, and a target that holds SCL low simply stretches the cycle.

A byte engine alongside uses three one-cycle strobes: one where the block begins pulling SCL low, one where the line is seen high, and one in the middle of the high phase for sampling data.

Top module: `scl_phase_gen`

## Requirements
- R1: While synchronous reset is held, and on the cycle after it, `scl_oe` is 0 and all three strobes are 0.
- R2: When `en` is sampled high in the idle state, `scl_oe` goes to 1 and `fall_stb` pulses on the following cycle.
- R3: The low phase (`scl_oe`=1) lasts max(low count, 2) ticks. A count of 0 or 1 gives 2 ticks.
- R4: After `scl_oe` is released and the line rises, `rise_stb` pulses exactly 3 cycles later. This covers the two synchronizer flops plus one decision cycle. High counting starts there.
- R5: While the line is held low externally after release, no `rise_stb` occurs. Once the line is freed, `rise_stb` follows 3 cycles later.
- R6: From `rise_stb` to the next `fall_stb` there are max(high count, 1) ticks. A count of 0 gives 1 tick.
- R7: `mid_stb` pulses tick_len*(floor(H/2)+1) cycles after `rise_stb`, where H is the effective high count.
- R8: `tick_div2`=0 makes one tick equal one clock. `tick_div2`=1 makes one tick equal two clocks. All phase lengths scale by this factor.
- R9: With `EXT_MSB`=1, counts are 9 bits and reach 0x1FF. With `EXT_MSB`=0, bit 8 of each count is ignored and the maximum is 0xFF. For example, 0x103 acts as 3.
- R10: When `en` is sampled low, `scl_oe` is 0 and all strobes are 0 from the next cycle. The counters are cleared, so a later enable starts with a full-length low phase.
- R11: Each strobe lasts one cycle, and `fall_stb` and `rise_stb` never coincide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low releases SCL and clears the counters |
| tick_div2 | input | 1 | 0: one clock per tick; 1: two clocks per tick |
| low_count | input | CNT_W | Low phase length in ticks (bit 8 is the extension bit) |
| high_count | input | CNT_W | High phase length in ticks (bit 8 is the extension bit) |
| scl_in | input | 1 | Observed SCL line level (asynchronous) |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| fall_stb | output | 1 | One-cycle pulse when the block starts pulling SCL low |
| rise_stb | output | 1 | One-cycle pulse when synchronized SCL is seen high |
| mid_stb | output | 1 | One-cycle pulse at the middle of the high phase |

## Verification
The hardest case to reach from the ports is a target stretching the clock. The bench wires SCL as a wired-AND of `scl_oe` and an extra bench-driven pull. It keeps that pull active across a release for a dozen cycles, checks that no rising strobe appears, then frees the line and measures the 3-cycle lag.

The extension bit is checked on a second instance built without it, using a count whose bit 8 is set. Disabling is applied in the middle of a high phase, followed by a re-enable that must begin with a full low phase.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_LOW     = 2'd1,
        PH_RELEASE = 2'd2,
        PH_HIGH    = 2'd3
    } scl_phase_e;

    typedef struct packed {
        logic fall;
        logic rise;
        logic mid;
    } scl_strobe_t;

    // Shortest low phase that keeps the synchronized level from going stale.
    localparam int unsigned MIN_LOW_TICKS  = 2;
    localparam int unsigned MIN_HIGH_TICKS = 1;

    function automatic int unsigned lim_floor(input int unsigned v, input int unsigned lo);
        return (v < lo) ? lo : v;
    endfunction

endpackage

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic stage_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= 1'b1;
                    else     stage_q[i] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= 1'b1;
                    else     stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/scl_tick_div.sv
module scl_tick_div #(
    parameter int PRE_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [PRE_W-1:0] div_m1,
    output logic             tick
);
    logic [PRE_W-1:0] pre_q;

    assign tick = (pre_q == div_m1);

    always_ff @(posedge clk) begin
        if (rst || restart) pre_q <= '0;
        else if (tick)      pre_q <= '0;
        else                pre_q <= pre_q + {{(PRE_W-1){1'b0}}, 1'b1};
    end

    // R8
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && div_m1 != '0) |=> (!tick || div_m1 == '0));

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int CNT_W   = 9,
    parameter bit EXT_MSB = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic             scl_s,
    input  logic [CNT_W-1:0] low_raw,
    input  logic [CNT_W-1:0] high_raw,
    output logic             restart,
    output logic             scl_oe,
    output scl_strobe_t      stb
);
    localparam logic [CNT_W-1:0] CNT_MASK = EXT_MSB ? {CNT_W{1'b1}} : {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] low_sel, high_sel, low_lim, high_lim;
    scl_phase_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             oe_q, oe_d;
    scl_strobe_t      stb_q, stb_d;

    assign low_sel  = low_raw  & CNT_MASK;
    assign high_sel = high_raw & CNT_MASK;
    assign low_lim  = CNT_W'(lim_floor(32'(low_sel),  MIN_LOW_TICKS));
    assign high_lim = CNT_W'(lim_floor(32'(high_sel), MIN_HIGH_TICKS));

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        oe_d    = oe_q;
        stb_d   = '0;
        restart = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                restart = 1'b1;
                if (en) begin
                    state_d    = PH_LOW;
                    oe_d       = 1'b1;
                    stb_d.fall = 1'b1;
                    cnt_d      = '0;
                end
            end
            PH_LOW: begin
                if (tick) begin
                    if (cnt_q == low_lim - ONE) begin
                        state_d = PH_RELEASE;
                        oe_d    = 1'b0;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
            end
            PH_RELEASE: begin
                if (scl_s) begin
                    state_d    = PH_HIGH;
                    stb_d.rise = 1'b1;
                    restart    = 1'b1;
                    cnt_d      = '0;
                end
            end
            PH_HIGH: begin
                if (tick) begin
                    if (cnt_q == (high_lim >> 1)) stb_d.mid = 1'b1;
                    if (cnt_q == high_lim - ONE) begin
                        state_d    = PH_LOW;
                        oe_d       = 1'b1;
                        stb_d.fall = 1'b1;
                        restart    = 1'b1;
                        cnt_d      = '0;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
            end
            default: state_d = PH_IDLE;
        endcase
        if (!en) begin
            state_d = PH_IDLE;
            cnt_d   = '0;
            oe_d    = 1'b0;
            stb_d   = '0;
            restart = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
            stb_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            oe_q    <= oe_d;
            stb_q   <= stb_d;
        end
    end

    assign scl_oe = oe_q;
    assign stb    = stb_q;

    // R3
    low_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_LOW) |-> (cnt_q < low_lim));

    // R4
    rise_after_high_chk: assert property (@(posedge clk) disable iff (rst)
        stb_q.rise |-> $past(scl_s));

    // R6
    high_released_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_HIGH) |-> !oe_q);

    // R2
    fall_with_pull_chk: assert property (@(posedge clk) disable iff (rst)
        stb_q.fall |-> oe_q);

    // R2
    pull_rise_marked_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_q) |-> stb_q.fall);

    // R10
    disable_release_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!oe_q && stb_q == '0));

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(stb_q.fall && stb_q.rise));

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
    parameter int CNT_W       = 9,
    parameter bit EXT_MSB     = 1'b1,
    parameter int SYNC_STAGES = 2,
    parameter int PRE_W       = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick_div2,
    input  logic [CNT_W-1:0] low_count,
    input  logic [CNT_W-1:0] high_count,
    input  logic             scl_in,
    output logic             scl_oe,
    output logic             fall_stb,
    output logic             rise_stb,
    output logic             mid_stb
);
    import scl_gen_pkg::*;

    logic        scl_s;
    logic        tick;
    logic        restart;
    scl_strobe_t stb;

    scl_in_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .async_in (scl_in),
        .sync_out (scl_s)
    );

    scl_tick_div #(.PRE_W(PRE_W)) div_i (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .div_m1  (PRE_W'(tick_div2)),
        .tick    (tick)
    );

    scl_phase_fsm #(.CNT_W(CNT_W), .EXT_MSB(EXT_MSB)) fsm_i (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .tick     (tick),
        .scl_s    (scl_s),
        .low_raw  (low_count),
        .high_raw (high_count),
        .restart  (restart),
        .scl_oe   (scl_oe),
        .stb      (stb)
    );

    assign fall_stb = stb.fall;
    assign rise_stb = stb.rise;
    assign mid_stb  = stb.mid;

endmodule

// File: tb/scl_phase_gen_tb_top.sv
module scl_phase_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       div2 = 1'b0;
    logic [8:0] low_c = 9'd4;
    logic [8:0] high_c = 9'd4;
    logic       stretch = 1'b0;
    logic       sel8 = 1'b0;

    logic oe_a, fall_a, rise_a, mid_a, scl_a;
    logic oe_b, fall_b, rise_b, mid_b, scl_b;
    logic m_oe, m_fall, m_rise, m_mid;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    assign scl_a = ~(oe_a | stretch);
    assign scl_b = ~oe_b;

    assign m_oe   = sel8 ? oe_b   : oe_a;
    assign m_fall = sel8 ? fall_b : fall_a;
    assign m_rise = sel8 ? rise_b : rise_a;
    assign m_mid  = sel8 ? mid_b  : mid_a;

    scl_phase_gen dut_i (
        .clk(clk), .rst(rst), .en(en), .tick_div2(div2),
        .low_count(low_c), .high_count(high_c), .scl_in(scl_a),
        .scl_oe(oe_a), .fall_stb(fall_a), .rise_stb(rise_a), .mid_stb(mid_a)
    );

    scl_phase_gen #(.EXT_MSB(1'b0)) dut8_i (
        .clk(clk), .rst(rst), .en(en), .tick_div2(div2),
        .low_count(low_c), .high_count(high_c), .scl_in(scl_b),
        .scl_oe(oe_b), .fall_stb(fall_b), .rise_stb(rise_b), .mid_stb(mid_b)
    );

    localparam int NV = 6;
    localparam int VL [NV] = '{5, 300, 1, 7, 3, 0};
    localparam int VH [NV] = '{4, 2, 0, 6, 9, 5};
    localparam int VD [NV] = '{0, 0, 0, 1, 1, 1};

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_eff(input int raw, input bit ext, input int lo);
        int v;
        v = ext ? raw : (raw & 255);
        return (v < lo) ? lo : v;
    endfunction

    task automatic run_vec(input int l, input int h, input bit d, input bit use8, input string lreq);
        int le, he, dv, n;
        sel8 = use8;
        low_c = 9'(l);
        high_c = 9'(h);
        div2 = d;
        dv = d ? 2 : 1;
        le = exp_eff(l, !use8, 2);
        he = exp_eff(h, !use8, 1);
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        check_eq("R2 fall strobe on enable", int'(m_fall && m_oe), 1);
        n = 0;
        while (m_oe) begin
            n++;
            @(negedge clk);
            if (n == 1) check_eq("R11 fall strobe one cycle", int'(m_fall), 0);
        end
        check_eq({lreq, " R8 low phase length"}, n, le * dv);
        n = 0;
        while (!m_rise) begin
            n++;
            @(negedge clk);
        end
        check_eq("R4 release to rise lag", n, 3);
        n = 0;
        while (!m_mid) begin
            @(negedge clk);
            n++;
        end
        check_eq("R7 mid strobe offset", n, dv * (he / 2 + 1));
        while (!m_fall) begin
            @(negedge clk);
            n++;
        end
        check_eq("R6 high phase length", n, he * dv);
        en = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seen;
        int n;
        // R1: reset state
        repeat (3) @(negedge clk);
        check_eq("R1 oe in reset", int'(oe_a), 0);
        check_eq("R1 strobes in reset", int'(fall_a | rise_a | mid_a), 0);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 oe after reset", int'(oe_a), 0);
        check_eq("R1 strobes after reset", int'(fall_a | rise_a | mid_a), 0);

        // Table walk: R3, R6, R7, R8, R9
        for (int i = 0; i < NV; i++) begin
            run_vec(VL[i], VH[i], VD[i] != 0, 1'b0, (VL[i] > 255) ? "R9" : "R3");
        end

        // R9: bit 8 ignored without extension
        run_vec(32'h103, 32'h102, 1'b0, 1'b1, "R9");
        sel8 = 1'b0;

        // R5: clock stretching by a target
        low_c = 9'd4; high_c = 9'd4; div2 = 1'b0;
        stretch = 1'b1;
        en = 1'b1;
        @(negedge clk);
        while (oe_a) @(negedge clk);
        seen = 0;
        for (int k = 0; k < 12; k++) begin
            if (rise_a) seen++;
            @(negedge clk);
        end
        check_eq("R5 no rise while held low", seen, 0);
        stretch = 1'b0;
        n = 0;
        while (!rise_a) begin
            @(negedge clk);
            n++;
        end
        check_eq("R5 rise lag after stretch", n, 3);
        en = 1'b0;
        @(negedge clk);
        @(negedge clk);

        // R10: disable mid high phase, then full restart
        low_c = 9'd6; high_c = 9'd20; div2 = 1'b0;
        en = 1'b1;
        @(negedge clk);
        while (!rise_a) @(negedge clk);
        repeat (3) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check_eq("R10 oe released on disable", int'(oe_a), 0);
        seen = 0;
        for (int k = 0; k < 6; k++) begin
            if (oe_a | fall_a | rise_a | mid_a) seen++;
            @(negedge clk);
        end
        check_eq("R10 quiet while disabled", seen, 0);
        run_vec(6, 20, 1'b0, 1'b0, "R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule